// File: doc/BRIEF.md
# Dual-Write General Register File

This block holds the eight 32-bit general registers of a small processor core. Each register is named by a 4-bit identifier. Two read ports return register contents combinationally, for the two source operands of an instruction. Two write ports commit on the rising clock edge. The E port carries an execute-stage result and the M port carries a memory-stage result.

With two write ports, one instruction can update two registers in the same cycle. A stack pop is the usual case: the stack pointer (ID 4) is adjusted through one port while the loaded word lands in the destination register through the other.

Identifier 0xF is reserved to mean "no register". The other values from 8 to 14 are unused. Any port given one of these IDs does nothing: a read returns zero and a write is dropped. This lets the decode logic leave an operand slot empty without a separate enable. A flattened view of all eight registers is exposed for debug.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge clears all eight registers to 0 at that edge.
- R2: For a read ID from 0 to 7, each read port outputs the stored register combinationally. The register mapping is 0=eax, 1=ecx, 2=edx, 3=ebx, 4=esp, 5=ebp, 6=esi, 7=edi.
- R3: A read ID from 8 to 15, where 15 (0xF) is the null ID, makes that read port output 0.
- R4: A write ID from 0 to 7 on port E stores `wr_e_data` into that register at the rising edge.
- R5: A write ID from 0 to 7 on port M stores `wr_m_data` into that register at the rising edge.
- R6: When both write ports name the same valid ID in one cycle, the register takes the port M data.
- R7: A write ID from 8 to 15 on either port changes no register.
- R8: The read ports show the value held before the current cycle's write. There is no write-to-read bypass.
- R9: Two different valid IDs on E and M in the same cycle update both registers. An example is ID 4 (stack pointer) on E with a destination ID on M.
- R10: `dbg_regs[i*32 +: 32]` always equals register i, for i from 0 to 7.
- R11: A register named by neither write port keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_id | input | 4 | Read port A register ID |
| rd_a_data | output | 32 | Read port A data |
| rd_b_id | input | 4 | Read port B register ID |
| rd_b_data | output | 32 | Read port B data |
| wr_e_id | input | 4 | Write port E register ID (8..15 = no write) |
| wr_e_data | input | 32 | Write port E data |
| wr_m_id | input | 4 | Write port M register ID (8..15 = no write), wins on collision |
| wr_m_data | input | 32 | Write port M data |
| dbg_regs | output | 256 | All registers, register i at bits [i*32 +: 32] |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight registers, 4-bit IDs and a null ID of 0xF. With eight registers and sixteen ID codes, half the identifier space is invalid. Random ID picks therefore land on unused and null codes often, and also make same-register collisions between E and M frequent. Reads in the same cycle as a write to the same ID come up regularly, which exercises the no-bypass rule. Directed cycles cover the pop pattern on the stack pointer, a collision, and null writes on both ports.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_DATA_W   = 32;
  localparam int unsigned GPR_NUM_REGS = 8;
  localparam int unsigned GPR_ID_W     = 4;
  localparam int unsigned GPR_NULL_ID  = 15;

  localparam int unsigned GPR_ESP_ID = 4;
endpackage

// File: rtl/gpr_id_check.sv
// Flags whether an ID addresses a real register.
module gpr_id_check #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned NULL_ID  = 15
) (
  input  logic [ID_W-1:0] id,
  output logic            valid
);
  always_comb begin
    valid = (32'(id) < NUM_REGS) && (32'(id) != NULL_ID);
  end
endmodule

// File: rtl/gpr_rd_port.sv
// Combinational read port; invalid IDs return zero.
module gpr_rd_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NULL_ID  = 15
) (
  input  logic [ID_W-1:0]   id,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  output logic [DATA_W-1:0] data
);
  logic valid;

  gpr_id_check #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_chk (
    .id    (id),
    .valid (valid)
  );

  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (valid && (32'(id) == i)) data = regs[i];
    end
  end
endmodule

// File: rtl/gpr_wr_sel.sv
// Per-register write enable and data; port M has priority over port E.
module gpr_wr_sel #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NULL_ID  = 15
) (
  input  logic [ID_W-1:0]   e_id,
  input  logic [DATA_W-1:0] e_data,
  input  logic [ID_W-1:0]   m_id,
  input  logic [DATA_W-1:0] m_data,
  output logic [NUM_REGS-1:0] we,
  output logic [DATA_W-1:0]   wd [NUM_REGS]
);
  logic e_valid, m_valid;

  gpr_id_check #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_e_chk (
    .id    (e_id),
    .valid (e_valid)
  );
  gpr_id_check #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_m_chk (
    .id    (m_id),
    .valid (m_valid)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    logic hit_e, hit_m;
    always_comb begin
      hit_e = e_valid && (32'(e_id) == g);
      hit_m = m_valid && (32'(m_id) == g);
      we[g] = hit_e | hit_m;
      wd[g] = hit_m ? m_data : e_data;
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned DATA_W   = gpr_pkg::GPR_DATA_W,
  parameter int unsigned NUM_REGS = gpr_pkg::GPR_NUM_REGS,
  parameter int unsigned ID_W     = gpr_pkg::GPR_ID_W,
  parameter int unsigned NULL_ID  = gpr_pkg::GPR_NULL_ID,
  localparam int unsigned DBG_W   = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_e_id,
  input  logic [DATA_W-1:0] wr_e_data,
  input  logic [ID_W-1:0]   wr_m_id,
  input  logic [DATA_W-1:0] wr_m_data,
  output logic [DBG_W-1:0]  dbg_regs
);
  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] we;
  logic [DATA_W-1:0]   wd [NUM_REGS];

  gpr_wr_sel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W), .NULL_ID(NULL_ID)) u_wsel (
    .e_id   (wr_e_id),
    .e_data (wr_e_data),
    .m_id   (wr_m_id),
    .m_data (wr_m_data),
    .we     (we),
    .wd     (wd)
  );

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)        regs_q[i] <= '0;
      else if (we[i]) regs_q[i] <= wd[i];
    end
  end

  gpr_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W), .NULL_ID(NULL_ID)) u_rd_a (
    .id   (rd_a_id),
    .regs (regs_q),
    .data (rd_a_data)
  );
  gpr_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W), .NULL_ID(NULL_ID)) u_rd_b (
    .id   (rd_b_id),
    .regs (regs_q),
    .data (rd_b_data)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dbg
    assign dbg_regs[g*DATA_W +: DATA_W] = regs_q[g];
  end
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NULL_ID  = 15,
  localparam int unsigned DBG_W   = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   rd_a_id,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ID_W-1:0]   rd_b_id,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [ID_W-1:0]   wr_e_id,
  input logic [DATA_W-1:0] wr_e_data,
  input logic [ID_W-1:0]   wr_m_id,
  input logic [DATA_W-1:0] wr_m_data,
  input logic [DBG_W-1:0]  dbg_regs
);
  function automatic logic ok_id(input logic [ID_W-1:0] id);
    return (32'(id) < NUM_REGS) && (32'(id) != NULL_ID);
  endfunction

  function automatic logic [DATA_W-1:0] slot(input logic [DBG_W-1:0] v, input logic [ID_W-1:0] id);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_REGS; i++) if (32'(id) == i) r = v[i*DATA_W +: DATA_W];
    return r;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dbg_regs == '0));

  // R2, R8: reads match the stored (pre-write) contents
  assert_read_a_R2: assert property (@(posedge clk) disable iff (rst)
    ok_id(rd_a_id) |-> (rd_a_data == slot(dbg_regs, rd_a_id)));
  assert_read_b_R8: assert property (@(posedge clk) disable iff (rst)
    ok_id(rd_b_id) |-> (rd_b_data == slot(dbg_regs, rd_b_id)));

  assert_null_read_a_R3: assert property (@(posedge clk) disable iff (rst)
    !ok_id(rd_a_id) |-> (rd_a_data == '0));
  assert_null_read_b_R3: assert property (@(posedge clk) disable iff (rst)
    !ok_id(rd_b_id) |-> (rd_b_data == '0));

  assert_port_e_write_R4: assert property (@(posedge clk) disable iff (rst)
    (ok_id(wr_e_id) && (wr_e_id != wr_m_id)) |=> (slot(dbg_regs, $past(wr_e_id)) == $past(wr_e_data)));

  // R5 and R6: port M always lands, including on collision
  assert_port_m_write_R5: assert property (@(posedge clk) disable iff (rst)
    ok_id(wr_m_id) |=> (slot(dbg_regs, $past(wr_m_id)) == $past(wr_m_data)));

  // R7, R11: untouched registers hold
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !((ok_id(wr_e_id) && 32'(wr_e_id) == g) || (ok_id(wr_m_id) && 32'(wr_m_id) == g))
      |=> $stable(dbg_regs[g*DATA_W +: DATA_W]));
  end
endmodule

bind gpr_file gpr_file_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W), .NULL_ID(NULL_ID)
) u_gpr_chk (.*);

// File: tb/gpr_file_test.sv
module gpr_file_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_id = 4'hF, rd_b_id = 4'hF, wr_e_id = 4'hF, wr_m_id = 4'hF;
  logic [31:0] wr_e_data = '0, wr_m_data = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic [255:0] dbg_regs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_file uut (
    .clk(clk), .rst(rst),
    .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_e_id(wr_e_id), .wr_e_data(wr_e_data),
    .wr_m_id(wr_m_id), .wr_m_data(wr_m_data),
    .dbg_regs(dbg_regs)
  );

  function automatic bit is_valid(input logic [3:0] id);
    return id < 4'd8;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] id);
    return is_valid(id) ? model[id[2:0]] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ra, input logic [3:0] rb,
                      input logic [3:0] ei, input logic [31:0] ed,
                      input logic [3:0] mi, input logic [31:0] md);
    @(negedge clk);
    rd_a_id = ra; rd_b_id = rb;
    wr_e_id = ei; wr_e_data = ed;
    wr_m_id = mi; wr_m_data = md;
    #1;
    // R2/R3 plus R8: value before this cycle's write
    chk(rd_a_data == exp_read(ra), is_valid(ra) ? ((ra == ei || ra == mi) ? "R8" : "R2") : "R3",
        rd_a_data, exp_read(ra));
    chk(rd_b_data == exp_read(rb), is_valid(rb) ? ((rb == ei || rb == mi) ? "R8" : "R2") : "R3",
        rd_b_data, exp_read(rb));
    @(posedge clk);
    if (is_valid(ei)) model[ei[2:0]] = ed;
    if (is_valid(mi)) model[mi[2:0]] = md;
    #1;
    for (int i = 0; i < 8; i++) begin
      string tag;
      bit he, hm;
      he = is_valid(ei) && ei == 4'(i);
      hm = is_valid(mi) && mi == 4'(i);
      if (he && hm)   tag = "R6";
      else if (hm)    tag = "R5";
      else if (he)    tag = "R4";
      else if (!is_valid(ei) || !is_valid(mi)) tag = "R7";
      else            tag = "R11";
      chk(dbg_regs[i*32 +: 32] == model[i], tag, dbg_regs[i*32 +: 32], model[i]);
    end
  endtask

  function automatic logic [3:0] pick_id();
    int unsigned r;
    r = $urandom % 16;
    return (r < 11) ? 4'(r % 8) : 4'(r);
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(dbg_regs == '0, "R1", dbg_regs[31:0], 32'h0);

    // fill registers through both ports
    for (int i = 0; i < 8; i += 2)
      step(4'hF, 4'hF, 4'(i), 32'h1000_0000 + 32'(i), 4'(i + 1), 32'h2000_0000 + 32'(i));

    // R10 layout: register 5 at bits [191:160]
    chk(dbg_regs[191:160] == 32'h2000_0004, "R10", dbg_regs[191:160], 32'h2000_0004);

    // R9: pop pattern, stack pointer on E, destination on M
    step(4'd4, 4'd2, 4'd4, 32'h0000_0F04, 4'd2, 32'hCAFE_0002);
    chk(dbg_regs[4*32 +: 32] == 32'h0000_0F04, "R9", dbg_regs[4*32 +: 32], 32'h0000_0F04);
    chk(dbg_regs[2*32 +: 32] == 32'hCAFE_0002, "R9", dbg_regs[2*32 +: 32], 32'hCAFE_0002);

    // R6: collision, M wins
    step(4'd3, 4'd3, 4'd3, 32'hEEEE_EEEE, 4'd3, 32'hAAAA_AAAA);
    chk(dbg_regs[3*32 +: 32] == 32'hAAAA_AAAA, "R6", dbg_regs[3*32 +: 32], 32'hAAAA_AAAA);

    // R7: null and unused write IDs
    step(4'hF, 4'd8, 4'hF, 32'hDEAD_BEEF, 4'd14, 32'hBAD0_BAD0);
    step(4'd9, 4'hF, 4'd8, 32'h1234_5678, 4'hF, 32'h8765_4321);

    // R8: read same register being written
    step(4'd6, 4'd7, 4'd6, 32'h6666_6666, 4'd7, 32'h7777_7777);
    step(4'd6, 4'd7, 4'hF, 32'h0, 4'hF, 32'h0);

    for (int n = 0; n < 3000; n++)
      step(pick_id(), pick_id(), pick_id(), $urandom, pick_id(), $urandom);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    wr_e_id = 4'd1; wr_e_data = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) model[i] = '0;
    chk(dbg_regs == '0, "R1", dbg_regs[63:32], 32'h0);
    @(negedge clk);
    rst = 1'b0;
    wr_e_id = 4'hF;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule